// File: doc/BRIEF.md
# Strap-Gated 64-bit Memory Window Decoder

This block keeps a 64-bit memory window base in two 32-bit configuration registers, a low half and a high half, and uses it to decode memory accesses on both sides of a bridge. The window is 1 MiB aligned. Address bits 63:20 of an access are compared with bits 63:20 of the base, and bits 19:0 take no part.

A hit means different things on each side. On the upstream (primary) side, a hit tells the bridge to claim the access and forward it downstream. On the downstream (secondary) side, a hit tells the bridge to leave the access alone. A hardware strap input enables the window. With the strap low, the high register reads as zero, it takes no writes, and the whole window is off on both sides.

Software reaches the registers through a simple port with a dword offset, write data, byte enables and read data. Writes take effect on the clock edge. Reads and decode outputs are combinational from the stored values.

Top module: `mwin_decode_top`

## Requirements
- R1: After reset both base registers read 0x00000000.
- R2: The high base register is at dword offset 0x14 (byte address 0x14, index 5). With the strap high, all 32 bits of it can be read and written.
- R3: The low base register is at offset 0x10 (index 4). Its bits 31:20 can be read and written. Its bits 19:0 always read as zero.
- R4: Each write-enable bit i (i = 0..3) updates only data byte i (bits 8i+7:8i) of the addressed register. Bytes whose enable is clear keep their value.
- R5: With the strap low, reads at offset 0x14 return zero and writes there have no effect. The stored high value is not changed by such a write.
- R6: With the strap high, a valid primary access whose address bits 63:20 equal base bits 63:20 raises the claim output and the forward output in the same cycle.
- R7: With the strap high, a valid secondary access whose bits 63:20 match the base raises the ignore output. An access that does not match leaves it low.
- R8: Address bits 19:0 never affect either decode.
- R9: With the strap low, the claim, forward and ignore outputs are all low, whatever the address.
- R10: When an access is flagged as 32-bit, its bits 63:32 are taken as zero for the comparison.
- R11: Reads at any other offset return zero, and writes there change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | Window enable strap |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Dword index (offset/4) |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data |
| pri_valid | input | 1 | Primary access present |
| pri_addr | input | 64 | Primary access address |
| pri_dac32 | input | 1 | Primary address is 32-bit |
| pri_claim | output | 1 | Claim primary access |
| pri_fwd | output | 1 | Forward primary access downstream |
| sec_valid | input | 1 | Secondary access present |
| sec_addr | input | 64 | Secondary access address |
| sec_dac32 | input | 1 | Secondary address is 32-bit |
| sec_ignore | output | 1 | Ignore secondary access |

## Verification
The two functions that can fall in the same cycle are a base-register write and a decode. The bench presents one address on both sides while it writes a new high base in the same cycle. Before the edge, the decode must follow the old base. After the edge, it must follow the new one. The bench also drives primary and secondary hits together and checks that claim and ignore assert in the same cycle.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 64;
  localparam int unsigned GRAN_LSB = 20;
  localparam int unsigned IDX_W    = 6;
  localparam int unsigned BE_W     = DW / 8;
  localparam logic [IDX_W-1:0] IDX_LO = 6'd4;
  localparam logic [IDX_W-1:0] IDX_HI = 6'd5;
  localparam int unsigned CMP_W    = AW - GRAN_LSB;
endpackage

// File: rtl/mwin_regs.sv
module mwin_regs
  import mwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_en,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [BE_W-1:0]  cfg_be,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  output logic [AW-1:0]    base
);
  logic [DW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic          lo_en, hi_en;
  logic [DW-1:0] lo_mask;

  assign lo_mask = {{(DW-GRAN_LSB){1'b1}}, {GRAN_LSB{1'b0}}};
  assign lo_en   = cfg_wr && (cfg_idx == IDX_LO);
  assign hi_en   = cfg_wr && (cfg_idx == IDX_HI) && strap_en;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    for (int b = 0; b < int'(BE_W); b++) begin
      if (cfg_be[b]) begin
        lo_d[b*8 +: 8] = cfg_wdata[b*8 +: 8];
        hi_d[b*8 +: 8] = cfg_wdata[b*8 +: 8];
      end
    end
    lo_d = lo_d & lo_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx == IDX_LO) cfg_rdata = lo_q;
    else if (cfg_idx == IDX_HI && strap_en) cfg_rdata = hi_q;
  end

  assign base = {hi_q, lo_q};

  // R5
  hi_strap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |=> $stable(hi_q));
  // R3
  lo_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q[GRAN_LSB-1:0] == '0);
  // R11
  other_idx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx != IDX_LO && cfg_idx != IDX_HI) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/mwin_match.sv
module mwin_match
  import mwin_pkg::*;
(
  input  logic          enable,
  input  logic          valid,
  input  logic          narrow,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          hit
);
  logic [AW-1:0] eff;
  always_comb begin
    eff = addr;
    if (narrow) eff[AW-1:DW] = '0;
  end
  assign hit = enable && valid && (eff[AW-1:GRAN_LSB] == base[AW-1:GRAN_LSB]);
endmodule

// File: rtl/mwin_decode_top.sv
module mwin_decode_top
  import mwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_en,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [BE_W-1:0]  cfg_be,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             pri_valid,
  input  logic [AW-1:0]    pri_addr,
  input  logic             pri_dac32,
  output logic             pri_claim,
  output logic             pri_fwd,
  input  logic             sec_valid,
  input  logic [AW-1:0]    sec_addr,
  input  logic             sec_dac32,
  output logic             sec_ignore
);
  logic [AW-1:0] base;
  logic          p_hit, s_hit;

  mwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .cfg_wr(cfg_wr),
    .cfg_idx(cfg_idx), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .base(base)
  );

  mwin_match u_pri (
    .enable(strap_en), .valid(pri_valid), .narrow(pri_dac32),
    .addr(pri_addr), .base(base), .hit(p_hit)
  );

  mwin_match u_sec (
    .enable(strap_en), .valid(sec_valid), .narrow(sec_dac32),
    .addr(sec_addr), .base(base), .hit(s_hit)
  );

  assign pri_claim  = p_hit;
  assign pri_fwd    = p_hit;
  assign sec_ignore = s_hit;

  // R9
  strap_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |-> !(pri_claim || pri_fwd || sec_ignore));
  // R6
  claim_fwd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_claim == pri_fwd);
  // R7
  ignore_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ignore |-> (sec_valid && strap_en));
  // R6
  claim_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_claim |-> (pri_valid && strap_en));
endmodule

// File: tb/mwin_decode_top_test.sv
module mwin_decode_top_test;
  logic clk = 0, rst_n = 0;
  logic strap_en = 1, cfg_wr = 0;
  logic [5:0] cfg_idx = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic pri_valid = 0, pri_dac32 = 0, sec_valid = 0, sec_dac32 = 0;
  logic [63:0] pri_addr = 0, sec_addr = 0;
  logic pri_claim, pri_fwd, sec_ignore;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  mwin_decode_top uut (.*);

  typedef struct packed {
    logic        strap;
    logic [5:0]  idx;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b1, 6'd4, 4'hF, 32'h1234_5678, 32'h1230_0000},  // R3
    '{1'b1, 6'd5, 4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2
    '{1'b1, 6'd5, 4'h2, 32'h0000_1100, 32'hDEAD_11EF},  // R4
    '{1'b1, 6'd4, 4'h8, 32'hAB00_0000, 32'hAB30_0000},  // R4
    '{1'b0, 6'd5, 4'hF, 32'h0000_0000, 32'h0000_0000},  // R5
    '{1'b1, 6'd5, 4'h0, 32'h0000_0000, 32'hDEAD_11EF},  // R5 held
    '{1'b1, 6'd7, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    '{1'b1, 6'd4, 4'h0, 32'h0000_0000, 32'hAB30_0000},  // R11
    '{1'b1, 6'd5, 4'h0, 32'h0000_0000, 32'hDEAD_11EF}   // R11
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] i, logic [3:0] b, logic [31:0] d);
    @(negedge clk); cfg_idx = i; cfg_be = b; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(logic [5:0] i, output logic [31:0] d);
    @(negedge clk); cfg_idx = i; #1 d = cfg_rdata;
  endtask

  task automatic dec(logic [63:0] pa, logic [63:0] sa, logic p32, logic s32);
    pri_addr = pa; sec_addr = sa; pri_dac32 = p32; sec_dac32 = s32;
    pri_valid = 1; sec_valid = 1; #1;
  endtask

  initial begin
    #50000; nfail++; $display("FAIL watchdog act=1 exp=0");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(6'd4, r); chk("R1", r, 0);
    rd(6'd5, r); chk("R1", r, 0);
    for (int k = 0; k < NV; k++) begin
      @(negedge clk); strap_en = VT[k].strap;
      if (VT[k].be != 0) wr(VT[k].idx, VT[k].be, VT[k].wd);
      if (VT[k].idx == 6'd7) begin
        rd(6'd7, r); chk("R11", r, 0);
      end else begin
        rd(VT[k].idx, r);
        chk("R2/R3/R4/R5", r, VT[k].exp_rd);
      end
    end
    // base now DEAD11EF_AB300000
    @(negedge clk); strap_en = 1;
    dec(64'hDEAD_11EF_AB3F_FFFF, 64'hDEAD_11EF_AB30_0001, 0, 0);
    chk("R6 claim", pri_claim, 1); chk("R6 fwd", pri_fwd, 1);
    chk("R7 ignore", sec_ignore, 1); chk("R8 low bits", pri_claim & sec_ignore, 1);
    dec(64'hDEAD_11EF_AB40_0000, 64'hDEAD_11EE_AB30_0000, 0, 0);
    chk("R6 miss", pri_claim, 0); chk("R7 miss", sec_ignore, 0);
    pri_valid = 0; #1 chk("R6 valid", pri_claim, 0);
    strap_en = 0;
    dec(64'hDEAD_11EF_AB30_0000, 64'hDEAD_11EF_AB30_0000, 0, 0);
    chk("R9 claim", pri_claim, 0); chk("R9 ignore", sec_ignore, 0);
    rd(6'd5, r); chk("R5 read", r, 0);
    // R10: high = 0
    @(negedge clk); strap_en = 1; wr(6'd5, 4'hF, 0);
    dec(64'hFFFF_FFFF_AB35_5555, 64'h0000_0001_AB30_0000, 1, 0);
    chk("R10 narrow hit", pri_claim, 1); chk("R10 wide miss", sec_ignore, 0);
    // same-cycle write and decode
    dec(64'h0000_0007_AB30_0000, 64'h0000_0007_AB30_0000, 0, 0);
    @(negedge clk); cfg_idx = 5; cfg_be = 4'hF; cfg_wdata = 32'h7; cfg_wr = 1; #1;
    chk("R6 old base", pri_claim, 0);
    @(negedge clk); cfg_wr = 0; #1;
    chk("R6 new base", pri_claim, 1); chk("R7 new base", sec_ignore, 1);
    // reset returns zero
    rst_n = 0; #1 rd(6'd5, r); chk("R1 rereset", r, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule